// File: doc/BRIEF.md
# SD/MMC Command Line Engine

This block drives one command frame onto the bidirectional command line of an SD or MMC card and, when asked, collects the card's reply. A control agent writes a command word together with a 32-bit argument. The block then serialises a 48-bit frame with its CRC7. It either finishes at once or listens for a 48-bit or 136-bit reply. The reply's CRC is checked, and the reply is placed into four 32-bit response words.

Card-clock timing comes from an external divider as two single-cycle strobes in the system clock domain. One marks the card clock's falling edge, where the block changes what it drives. The other marks the rising edge, where it samples the line. Completion and errors are reported by sticky status flags that a write-one-to-clear vector resets. A command word is a one-cycle strobe, not a stream. A word that arrives while a command is in flight is dropped, so the agent polls the busy flag before it issues the next word.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset, `status` is all zero, `cmd_oe` is low, `cmd_out` is high and all four response words are zero.
- R2: When `cmd_wr` is high, `cmd_word[10]` is set and no command is active, the block drives 48 bits on successive `tick_fall` strobes. The bits go out most significant first, in this order: 0, 1, `cmd_word[5:0]`, the argument, then CRC7 and a final 1. The CRC7 uses x^7+x^3+1 with a zero start and covers the first 40 bits. `cmd_oe` is high for exactly those 48 card cycles and low afterwards.
- R3: A `cmd_wr` with `cmd_word[10]` clear sends nothing and leaves `status` unchanged.
- R4: With `cmd_word[6]` clear, no reply is awaited and `status[7]` (sent) sets once the final bit's card cycle ends.
- R5: With `cmd_word[6]` set and `cmd_word[7]` clear, a 48-bit reply is sampled on `tick_rise`. Its CRC7 covers its first 40 bits. If the CRC matches, `status[6]` (reply received) sets. `resp0` takes the 32 bits that follow the first 8 reply bits, and `resp1` to `resp3` become zero.
- R6: With `cmd_word[6]` and `cmd_word[7]` set, a 136-bit reply is received. Number its bits 135 (start) down to 0 (end). `resp0` gets bits 127..96, `resp1` gets 95..64, `resp2` gets 63..32 and `resp3` gets 31..1 with its bit 0 forced to zero.
- R7: A reply whose CRC field mismatches sets `status[0]` instead of `status[6]`. The response words are still updated.
- R8: A reply's start bit is a 0 sampled on `tick_rise`, counting from the first rising edge after the final command bit. If the first 64 such samples are all high, `status[2]` (timeout) sets and the command ends. A start bit on the 64th sample is still accepted.
- R9: Flags in bits 0, 2, 6 and 7 stay set until a cycle in which the matching `sts_clr` bit is high. Clear bits for other flags leave a flag unchanged.
- R10: `status[11]` is high from the cycle after launch until the command ends. Command words arriving while it is high are ignored and do not alter the frame in progress.
- R11: A set `cmd_word[7]` with `cmd_word[6]` clear is treated as no reply, ending in `status[7]`.
- R12: For a 136-bit reply the CRC7 covers only bits 127..8 (after the 8 leading bits), so the values of the 6 reserved header bits do not affect the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_rise | input | 1 | One-cycle strobe: card clock rising edge (sample) |
| tick_fall | input | 1 | One-cycle strobe: card clock falling edge (drive) |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 16 | [5:0] index, [6] await reply, [7] long reply, [10] enable |
| cmd_arg | input | 32 | Command argument, captured at launch |
| sts_clr | input | 12 | Write-one-to-clear for status flags |
| status | output | 12 | [0] CRC fail, [2] timeout, [6] reply received, [7] sent, [11] active |
| resp0 | output | 32 | Response word 0 |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |
| cmd_out | output | 1 | Value driven on the command line |
| cmd_oe | output | 1 | Drive enable for the command line |
| cmd_in | input | 1 | Sampled command line level |

## Verification
The bench models a card that echoes frames and replies after a random number of idle cycles. It targets the timeout edge, where a start bit on the 64th sample must be accepted and 64 high samples must time out. A design off by one there either gives up early or waits too long. Corrupted CRCs in short and long replies must raise the fail flag, and flipped reserved header bits must not. A design that took the wrong CRC window would report the opposite. A second command is injected mid-frame, a disabled word is sent and the long-without-wait combination is tried. Partial clear masks are also applied. A design that relaunches, latches the new argument or clears the wrong flag shows up as a wrong frame bit or a wrong status value.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  // command word control bit positions (decoded by the engine)
  localparam int CW_WAIT = 6;
  localparam int CW_LONG = 7;
  localparam int CW_EN   = 10;
  // status bit positions
  localparam int ST_CRCFAIL = 0;
  localparam int ST_TMO     = 2;
  localparam int ST_REND    = 6;
  localparam int ST_SENT    = 7;
  localparam int ST_ACT     = 11;
  localparam int STS_W      = 12;

  typedef enum logic [1:0] {PH_IDLE, PH_TX, PH_RX} phase_e;

  // one serial step of CRC7, polynomial x^7 + x^3 + 1
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ {3'b000, fb, 2'b00, fb};
  endfunction
endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       din,
  output logic [6:0] crc
);
  import sdcmd_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= crc7_step(crc, din);
  end
endmodule

// File: rtl/sdcmd_tx.sv
module sdcmd_tx #(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_fall,
  input  logic             start,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  output logic             cmd_out,
  output logic             cmd_oe,
  output logic             done
);
  import sdcmd_pkg::*;

  localparam int HEAD_W  = 2 + IDX_W + ARG_W;
  localparam int FRAME_W = HEAD_W + 8;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [HEAD_W-1:0]  head;
  logic [6:0]         head_crc;
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cnt;
  logic               busy;

  assign head = {2'b01, idx, arg};

  always_comb begin
    head_crc = '0;
    for (int i = HEAD_W - 1; i >= 0; i--) head_crc = crc7_step(head_crc, head[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sh <= '0; cnt <= '0;
      cmd_out <= 1'b1; cmd_oe <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        sh   <= {head, head_crc, 1'b1};
        cnt  <= '0;
      end else if (busy && tick_fall) begin
        if (cnt == CNT_W'(FRAME_W)) begin
          busy    <= 1'b0;
          cmd_oe  <= 1'b0;
          cmd_out <= 1'b1;
          done    <= 1'b1;
        end else begin
          cmd_out <= sh[FRAME_W-1];
          cmd_oe  <= 1'b1;
          sh      <= {sh[FRAME_W-2:0], 1'b0};
          cnt     <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx #(
  parameter int SHORT_W = 48,
  parameter int LONG_W  = 136,
  parameter int TMO_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_rise,
  input  logic              start,
  input  logic              long_resp,
  input  logic              cmd_in,
  output logic              done,
  output logic              timeout,
  output logic              crc_ok,
  output logic [LONG_W-1:0] data
);
  localparam int CNT_W   = $clog2(LONG_W + 1);
  localparam int TMO_W   = $clog2(TMO_CYC + 1);
  localparam int S_LAST  = SHORT_W - 8;   // last CRC-covered bit, short reply
  localparam int L_FIRST = 9;             // first CRC-covered bit, long reply
  localparam int L_LAST  = LONG_W - 8;    // last CRC-covered bit, long reply

  logic             waiting, recv;
  logic [CNT_W-1:0] cnt, pos, total;
  logic [TMO_W-1:0] tmo;
  logic             in_region, crc_en;
  logic [6:0]       crc_q;

  assign pos       = cnt + CNT_W'(1);
  assign total     = long_resp ? CNT_W'(LONG_W) : CNT_W'(SHORT_W);
  assign in_region = long_resp ? (pos >= CNT_W'(L_FIRST) && pos <= CNT_W'(L_LAST))
                               : (pos <= CNT_W'(S_LAST));
  assign crc_en    = tick_rise && ((waiting && !cmd_in) || recv) && in_region;

  sdcmd_crc7 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(start), .en(crc_en), .din(cmd_in), .crc(crc_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting <= 1'b0; recv <= 1'b0; cnt <= '0; tmo <= '0;
      data <= '0; done <= 1'b0; timeout <= 1'b0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      if (start) begin
        waiting <= 1'b1; recv <= 1'b0; cnt <= '0; tmo <= '0; data <= '0;
      end else if (tick_rise) begin
        if (waiting) begin
          if (!cmd_in) begin
            waiting <= 1'b0;
            recv    <= 1'b1;
            cnt     <= CNT_W'(1);
            data    <= {data[LONG_W-2:0], cmd_in};
          end else if (tmo == TMO_W'(TMO_CYC - 1)) begin
            waiting <= 1'b0;
            timeout <= 1'b1;
          end else begin
            tmo <= tmo + TMO_W'(1);
          end
        end else if (recv) begin
          data <= {data[LONG_W-2:0], cmd_in};
          cnt  <= pos;
          if (pos == total) begin
            recv <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  assign crc_ok = (crc_q == data[7:1]);
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine #(
  parameter int IDX_W      = 6,
  parameter int ARG_W      = 32,
  parameter int CW_W       = 16,
  parameter int TMO_CYC    = 64,
  parameter int RESP_WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_rise,
  input  logic                     tick_fall,
  input  logic                     cmd_wr,
  input  logic [CW_W-1:0]          cmd_word,
  input  logic [ARG_W-1:0]         cmd_arg,
  input  logic [sdcmd_pkg::STS_W-1:0] sts_clr,
  output logic [sdcmd_pkg::STS_W-1:0] status,
  output logic [ARG_W-1:0]         resp0,
  output logic [ARG_W-1:0]         resp1,
  output logic [ARG_W-1:0]         resp2,
  output logic [ARG_W-1:0]         resp3,
  output logic                     cmd_out,
  output logic                     cmd_oe,
  input  logic                     cmd_in
);
  import sdcmd_pkg::*;

  localparam int SHORT_W = 2 + IDX_W + ARG_W + 8;
  localparam int LONG_W  = 8 + RESP_WORDS * ARG_W;
  localparam int LONG_HI = LONG_W - 9;
  localparam int SHORT_HI = SHORT_W - 9;

  phase_e ph;
  logic   want_q, long_q, launch;
  logic   tx_done, rx_start, rx_done, rx_tmo, rx_crc_ok;
  logic   [LONG_W-1:0] rx_data;
  logic   f_crc, f_tmo, f_rend, f_sent;
  logic   [RESP_WORDS-1:0][ARG_W-1:0] resp_q;
  logic   unused_bits;

  assign launch   = cmd_wr && cmd_word[CW_EN] && (ph == PH_IDLE);
  assign rx_start = (ph == PH_TX) && tx_done && want_q;

  sdcmd_tx #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick_fall(tick_fall), .start(launch),
    .idx(cmd_word[IDX_W-1:0]), .arg(cmd_arg),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .done(tx_done)
  );

  sdcmd_rx #(.SHORT_W(SHORT_W), .LONG_W(LONG_W), .TMO_CYC(TMO_CYC)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick_rise(tick_rise), .start(rx_start),
    .long_resp(long_q), .cmd_in(cmd_in), .done(rx_done), .timeout(rx_tmo),
    .crc_ok(rx_crc_ok), .data(rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; want_q <= 1'b0; long_q <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (launch) begin
          ph     <= PH_TX;
          want_q <= cmd_word[CW_WAIT];
          long_q <= cmd_word[CW_WAIT] & cmd_word[CW_LONG];
        end
        PH_TX:   if (tx_done) ph <= want_q ? PH_RX : PH_IDLE;
        PH_RX:   if (rx_done || rx_tmo) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // sticky flags: a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_crc <= 1'b0; f_tmo <= 1'b0; f_rend <= 1'b0; f_sent <= 1'b0;
    end else begin
      f_crc  <= (f_crc  & ~sts_clr[ST_CRCFAIL]) | (rx_done & ~rx_crc_ok);
      f_tmo  <= (f_tmo  & ~sts_clr[ST_TMO])     | rx_tmo;
      f_rend <= (f_rend & ~sts_clr[ST_REND])    | (rx_done & rx_crc_ok);
      f_sent <= (f_sent & ~sts_clr[ST_SENT])    | ((ph == PH_TX) & tx_done & ~want_q);
    end
  end

  always_comb begin
    status             = '0;
    status[ST_CRCFAIL] = f_crc;
    status[ST_TMO]     = f_tmo;
    status[ST_REND]    = f_rend;
    status[ST_SENT]    = f_sent;
    status[ST_ACT]     = (ph != PH_IDLE);
  end

  for (genvar w = 0; w < RESP_WORDS; w++) begin : g_resp
    localparam logic [ARG_W-1:0] MSK = (w == RESP_WORDS - 1) ? ~ARG_W'(1) : '1;
    logic [ARG_W-1:0] long_word, short_word;
    assign long_word  = rx_data[LONG_HI - ARG_W * w -: ARG_W] & MSK;
    assign short_word = (w == 0) ? rx_data[SHORT_HI -: ARG_W] : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       resp_q[w] <= '0;
      else if (rx_done) resp_q[w] <= long_q ? long_word : short_word;
    end
  end

  assign resp0 = resp_q[0];
  assign resp1 = resp_q[1];
  assign resp2 = resp_q[2];
  assign resp3 = resp_q[3];

  assign unused_bits = ^{cmd_word[CW_W-1:CW_EN+1], cmd_word[CW_EN-1:CW_LONG+1],
                         rx_data[LONG_W-1:LONG_HI+1]};
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic [15:0] cmd_word,
  input logic [11:0] sts_clr,
  input logic [11:0] status,
  input logic        cmd_oe
);
  // R10
  drive_implies_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> status[11]);

  // R3
  launch_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[11]) |-> $past(cmd_wr && cmd_word[10]));

  // R8
  timeout_ends_command_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> ($past(status[11]) && !status[11]));

  // R4
  sent_ends_command_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[7]) |-> ($past(status[11]) && !status[11]));

  // R9
  rend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status[6]) && !$past(sts_clr[6])) |-> status[6]);

  // R9
  crcfail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status[0]) && !$past(sts_clr[0])) |-> status[0]);
endmodule

bind sdcmd_engine sdcmd_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
  .sts_clr(sts_clr), .status(status), .cmd_oe(cmd_oe)
);

// File: tb/sdcmd_engine_tb_top.sv
module sdcmd_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_rise = 1'b0, tick_fall = 1'b0, cmd_wr = 1'b0, cmd_in = 1'b1;
  logic [15:0] cmd_word = '0;
  logic [31:0] cmd_arg = '0;
  logic [11:0] sts_clr = '0;
  logic [11:0] status;
  logic [31:0] resp0, resp1, resp2, resp3;
  logic cmd_out, cmd_oe;
  int total = 0, bad = 0;
  logic o, e;

  always #5 clk = ~clk;

  sdcmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .tick_rise(tick_rise), .tick_fall(tick_fall),
    .cmd_wr(cmd_wr), .cmd_word(cmd_word), .cmd_arg(cmd_arg), .sts_clr(sts_clr),
    .status(status), .resp0(resp0), .resp1(resp1), .resp2(resp2), .resp3(resp3),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in)
  );

  task automatic chk(input string req, input logic [135:0] act, input logic [135:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] bcrc(input logic [135:0] v, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [15:0] mkword(input logic en, input logic wt, input logic lg,
                                         input logic [5:0] idx);
    logic [15:0] w = '0;
    w[5:0] = idx; w[6] = wt; w[7] = lg; w[10] = en;
    return w;
  endfunction

  function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h = {2'b01, idx, arg};
    return {h, bcrc({96'd0, h}, 40), 1'b1};
  endfunction

  function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] d,
                                            input logic corrupt);
    logic [39:0] h = {2'b00, idx, d};
    logic [6:0] c = bcrc({96'd0, h}, 40) ^ {6'd0, corrupt};
    return {88'd0, h, c, 1'b1};
  endfunction

  function automatic logic [135:0] mk_long(input logic [119:0] body, input logic [5:0] rsv,
                                           input logic corrupt);
    logic [6:0] c = bcrc({16'd0, body}, 120) ^ {corrupt, 6'd0};
    return {2'b00, rsv, body, c, 1'b1};
  endfunction

  // one card clock period = four system cycles; called and returns at posedge+1
  task automatic cp(input logic drv, output logic obs, output logic oe);
    tick_fall = 1'b1;
    @(posedge clk); #1;
    tick_fall = 1'b0; obs = cmd_out; oe = cmd_oe; cmd_in = drv;
    @(posedge clk); #1;
    tick_rise = 1'b1;
    @(posedge clk); #1;
    tick_rise = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic issue(input logic [15:0] w, input logic [31:0] a);
    cmd_wr = 1'b1; cmd_word = w; cmd_arg = a;
    @(posedge clk); #1;
    cmd_wr = 1'b0;
  endtask

  task automatic clear(input logic [11:0] m);
    sts_clr = m;
    @(posedge clk); #1;
    sts_clr = '0;
  endtask

  // capture the 48 driven bits and the card cycle after them; optional injected command
  task automatic run_frame(output logic [47:0] f, input int inj_at,
                           input logic [15:0] w2, input logic [31:0] a2);
    int oe_miss = 0;
    f = '0;
    for (int i = 0; i < 48; i++) begin
      if (i == inj_at) issue(w2, a2);
      cp(1'b1, o, e);
      f = {f[46:0], o};
      if (!e) oe_miss++;
    end
    chk("R2 oe held for 48 bits", 136'(oe_miss), 136'd0);
    cp(1'b1, o, e);
    chk("R2 oe released after end bit", 136'(e), 136'd0);
  endtask

  task automatic respond(input int d, input logic [135:0] r, input int n);
    for (int i = 0; i < d; i++) cp(1'b1, o, e);
    for (int i = n - 1; i >= 0; i--) cp(r[i], o, e);
    cmd_in = 1'b1;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [47:0] f;
    logic [5:0] idx;
    logic [31:0] arg, d;
    logic [119:0] body;
    logic [135:0] r;
    void'($urandom(32'd4242));

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1
    chk("R1 status", 136'(status), 136'd0);
    chk("R1 cmd_oe", 136'(cmd_oe), 136'd0);
    chk("R1 cmd_out", 136'(cmd_out), 136'd1);
    chk("R1 resp", {8'd0, resp0, resp1, resp2, resp3}, 136'd0);

    // R3: enable bit clear
    issue(mkword(1'b0, 1'b1, 1'b0, 6'd17), 32'hDEAD_BEEF);
    for (int i = 0; i < 4; i++) begin
      cp(1'b1, o, e);
      chk("R3 no drive", 136'(e), 136'd0);
    end
    chk("R3 status unchanged", 136'(status), 136'd0);

    // R2 and R4: random no-reply commands
    for (int k = 0; k < 4; k++) begin
      idx = 6'($urandom); arg = $urandom;
      issue(mkword(1'b1, 1'b0, 1'b0, idx), arg);
      chk("R10 active after launch", 136'(status[11]), 136'd1);
      run_frame(f, -1, '0, '0);
      chk("R2 frame", 136'(f), 136'(exp_frame(idx, arg)));
      chk("R4 sent only", 136'(status), 136'h080);
      clear(12'h080);
      chk("R9 sent cleared", 136'(status), 136'd0);
    end

    // R11: long without wait
    issue(mkword(1'b1, 1'b0, 1'b1, 6'd9), 32'h1234_5678);
    run_frame(f, -1, '0, '0);
    repeat (3) cp(1'b1, o, e);
    chk("R11 treated as no reply", 136'(status), 136'h080);
    clear(12'h080);

    // R5: short replies with random delays
    for (int k = 0; k < 3; k++) begin
      idx = 6'($urandom); arg = $urandom; d = $urandom;
      issue(mkword(1'b1, 1'b1, 1'b0, idx), arg);
      run_frame(f, -1, '0, '0);
      chk("R2 frame with reply", 136'(f), 136'(exp_frame(idx, arg)));
      respond($urandom_range(20, 0), mk_short(idx, d, 1'b0), 48);
      chk("R5 reply received", 136'(status), 136'h040);
      chk("R5 resp0", 136'(resp0), 136'(d));
      chk("R5 upper words zero", {40'd0, resp1, resp2, resp3}, 136'd0);
      clear(12'h040);
    end

    // R7 and R9: bad short CRC, sticky behaviour
    d = 32'hA5A5_0F0F;
    issue(mkword(1'b1, 1'b1, 1'b0, 6'd13), 32'h0);
    run_frame(f, -1, '0, '0);
    respond(2, mk_short(6'd13, d, 1'b1), 48);
    chk("R7 crc fail flag", 136'(status), 136'h001);
    chk("R7 response still stored", 136'(resp0), 136'(d));
    repeat (5) cp(1'b1, o, e);
    chk("R9 flag stays", 136'(status), 136'h001);
    clear(12'hFFE);
    chk("R9 other clears ignored", 136'(status), 136'h001);
    clear(12'h001);
    chk("R9 cleared", 136'(status), 136'd0);

    // R6 and R12: long replies
    for (int k = 0; k < 3; k++) begin
      body = {$urandom, $urandom, $urandom, $urandom};
      r = mk_long(body, (k == 1) ? 6'b010101 : 6'b111111, k == 2);
      issue(mkword(1'b1, 1'b1, 1'b1, 6'd2), $urandom);
      run_frame(f, -1, '0, '0);
      respond(5, r, 136);
      if (k == 2) chk("R7 long crc fail", 136'(status), 136'h001);
      else if (k == 1) chk("R12 reserved bits outside crc", 136'(status), 136'h040);
      else chk("R6 long reply received", 136'(status), 136'h040);
      chk("R6 resp0", 136'(resp0), 136'(r[127:96]));
      chk("R6 resp1", 136'(resp1), 136'(r[95:64]));
      chk("R6 resp2", 136'(resp2), 136'(r[63:32]));
      chk("R6 resp3", 136'(resp3), 136'({r[31:1], 1'b0}));
      clear(12'h045);
    end

    // R8: start bit on the 64th sample is accepted
    issue(mkword(1'b1, 1'b1, 1'b0, 6'd7), 32'h0BAD_F00D);
    run_frame(f, -1, '0, '0);
    respond(62, mk_short(6'd7, 32'h7777_0001, 1'b0), 48);
    chk("R8 late start accepted", 136'(status), 136'h040);
    chk("R8 late resp0", 136'(resp0), 136'h7777_0001);
    clear(12'h040);

    // R8: 64 high samples time out
    issue(mkword(1'b1, 1'b1, 1'b0, 6'd8), 32'h0);
    run_frame(f, -1, '0, '0);
    for (int i = 0; i < 62; i++) cp(1'b1, o, e);
    chk("R8 no timeout at 63 samples", 136'(status), 136'h800);
    cp(1'b1, o, e);
    chk("R8 timeout at 64 samples", 136'(status), 136'h004);
    chk("R8 resp untouched", 136'(resp0), 136'h7777_0001);
    clear(12'h004);

    // R10: second command mid-frame is ignored
    issue(mkword(1'b1, 1'b0, 1'b0, 6'd21), 32'hCAFE_1234);
    run_frame(f, 10, mkword(1'b1, 1'b0, 1'b0, 6'd40), 32'h5555_AAAA);
    chk("R10 frame unchanged by injected word", 136'(f), 136'(exp_frame(6'd21, 32'hCAFE_1234)));
    repeat (3) cp(1'b1, o, e);
    chk("R10 no relaunch", 136'({status, cmd_oe}), 136'({12'h080, 1'b0}));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule